// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two 16-bit buses, A and B, and moves data between them. It is split into two 8-bit halves. Each half has its own enable, direction, select and capture-clock controls, so the halves can run as two separate byte-wide transceivers or be tied together and used as one 16-bit transceiver. Each bus is modelled as three signals: a data input, a data output and a per-bit output enable. There is no tristate pin.

Every half holds two storage registers. The A-to-B register samples the A bus when its capture clock rises. The B-to-A register samples the B bus when its own capture clock rises. For each direction a select input picks what drives the destination bus. It can pass the live data from the opposite bus through a purely combinational path, or it can pass the stored register. An active-low enable and a direction input decide which bus a half drives, if it drives one at all. The registers keep capturing while both buses are isolated.

Top module: `bus_xcvr16`

## Requirements
- R1: In each half, the A-to-B register loads that half's slice of `a_in` on a rising edge of that half's `ab_clk` bit. The value is visible on `b_out` once `sel_ab` for that half is 1.
- R2: In each half, the B-to-A register loads that half's slice of `b_in` on a rising edge of that half's `ba_clk` bit. The value is visible on `a_out` once `sel_ba` for that half is 1.
- R3: When `oe_n[h]` is 0 and `dir[h]` is 1, all 8 bits of `b_oe` for half h are 1 and all 8 bits of `a_oe` for half h are 0. With `sel_ab[h]` at 0, `b_out` follows `a_in` in the same cycle, with no clock in the path.
- R4: When `oe_n[h]` is 0 and `dir[h]` is 0, all 8 bits of `a_oe` for half h are 1 and `b_oe` for half h is 0. With `sel_ba[h]` at 0, `a_out` follows `b_in` in the same cycle.
- R5: When `oe_n[h]` is 1, both `a_oe` and `b_oe` for half h are 0. Both registers of that half still capture on their clock edges.
- R6: A select bit of 0 passes live data and a select bit of 1 passes stored data. The choice is a single 2:1 selection per bit, and changing the select bit changes the driven value without a clock.
- R7: Half h uses bits [8h+7:8h] of each bus and bit h of every control vector. A control or clock of one half has no effect on the other half.
- R8: While `rst_n` is 0, all output enables are 0 and both registers of every half are held at zero, asynchronously. After release, the stored value reads as zero until the next capture.
- R9: In transceiver mode, the bus that is not being driven can be captured into the register of either direction, or into both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n | input | 2 | Active-low enable, one bit per half |
| dir | input | 2 | Direction per half: 1 drives B from A, 0 drives A from B |
| ab_clk | input | 2 | A-to-B register capture clock per half |
| ba_clk | input | 2 | B-to-A register capture clock per half |
| sel_ab | input | 2 | Source for B output per half: 0 live A, 1 stored |
| sel_ba | input | 2 | Source for A output per half: 0 live B, 1 stored |
| a_in | input | 16 | Data seen on bus A |
| a_out | output | 16 | Data to drive onto bus A |
| a_oe | output | 16 | Per-bit drive enable for bus A |
| b_in | input | 16 | Data seen on bus B |
| b_out | output | 16 | Data to drive onto bus B |
| b_oe | output | 16 | Per-bit drive enable for bus B |

## Verification
The live paths and the enable decode have zero latency: the result is due in the same cycle the inputs change. The bench changes inputs on the falling bench edge and samples on the next rising edge. A stored value is due right after the rising edge of its capture clock. The bench raises that clock on a falling edge and pushes the expectation that reads it out only after the pulse has completed. The monitor then compares it at the following rising edge. Data outputs are compared only on bits whose expected enable is set, and the enables themselves are always compared.

// File: rtl/bxc_pkg.sv
package bxc_pkg;

    typedef struct packed {
        logic oe_n;
        logic dir;
        logic sel_ab;
        logic sel_ba;
    } hctl_t;

    typedef struct packed {
        logic drv_a;
        logic drv_b;
    } drive_t;

endpackage

// File: rtl/bxc_store_reg.sv
module bxc_store_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] q_d;
    logic [WIDTH-1:0] q_q;

    always_comb begin
        q_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;

    // R1 and R2: a capture edge loads the sampled input
    assert_capture_R1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q == $past(din)));

    // R8: after reset the stored value is zero until its first capture edge
    assert_reset_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (q == '0));

endmodule

// File: rtl/bxc_path_mux.sv
module bxc_path_mux #(
    parameter int WIDTH = 8
) (
    input  logic             sel,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] y
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign y[i] = sel ? stored[i] : live[i];
    end
endmodule

// File: rtl/bxc_drive_ctl.sv
module bxc_drive_ctl
    import bxc_pkg::*;
(
    input  logic   rst_n,
    input  hctl_t  ctl,
    output drive_t drv
);
    drive_t drv_d;

    always_comb begin
        drv_d = '0;
        if (rst_n && !ctl.oe_n) begin
            drv_d.drv_b = ctl.dir;
            drv_d.drv_a = !ctl.dir;
        end
    end

    assign drv = drv_d;
endmodule

// File: rtl/bxc_half.sv
module bxc_half
    import bxc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             rst_n,
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  hctl_t            ctl,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe
);
    logic [WIDTH-1:0] ab_q;
    logic [WIDTH-1:0] ba_q;
    drive_t           drv;

    bxc_store_reg #(.WIDTH(WIDTH)) u_ab_reg (
        .clk(clk_ab), .rst_n(rst_n), .din(a_in), .q(ab_q)
    );

    bxc_store_reg #(.WIDTH(WIDTH)) u_ba_reg (
        .clk(clk_ba), .rst_n(rst_n), .din(b_in), .q(ba_q)
    );

    bxc_path_mux #(.WIDTH(WIDTH)) u_mux_b (
        .sel(ctl.sel_ab), .live(a_in), .stored(ab_q), .y(b_out)
    );

    bxc_path_mux #(.WIDTH(WIDTH)) u_mux_a (
        .sel(ctl.sel_ba), .live(b_in), .stored(ba_q), .y(a_out)
    );

    bxc_drive_ctl u_drive (
        .rst_n(rst_n), .ctl(ctl), .drv(drv)
    );

    assign a_oe = {WIDTH{drv.drv_a}};
    assign b_oe = {WIDTH{drv.drv_b}};

    always_comb begin
        // R3 and R4: never both buses of one half driven
        assert_one_driver_R3: assert (!((|a_oe) && (|b_oe)));
        // R5: isolation leaves both buses undriven
        if (rst_n && ctl.oe_n) begin
            assert_isolation_R5: assert ((a_oe == '0) && (b_oe == '0));
        end
        // R8: enables are off during reset
        if (!rst_n) begin
            assert_reset_oe_R8: assert ((a_oe == '0) && (b_oe == '0));
        end
    end

endmodule

// File: rtl/bus_xcvr16.sv
module bus_xcvr16
    import bxc_pkg::*;
#(
    parameter int HALF_W  = 8,
    parameter int N_HALF  = 2,
    localparam int BUS_W  = HALF_W * N_HALF
) (
    input  logic              rst_n,
    input  logic [N_HALF-1:0] oe_n,
    input  logic [N_HALF-1:0] dir,
    input  logic [N_HALF-1:0] ab_clk,
    input  logic [N_HALF-1:0] ba_clk,
    input  logic [N_HALF-1:0] sel_ab,
    input  logic [N_HALF-1:0] sel_ba,
    input  logic [BUS_W-1:0]  a_in,
    output logic [BUS_W-1:0]  a_out,
    output logic [BUS_W-1:0]  a_oe,
    input  logic [BUS_W-1:0]  b_in,
    output logic [BUS_W-1:0]  b_out,
    output logic [BUS_W-1:0]  b_oe
);
    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        hctl_t ctl;

        always_comb begin
            ctl.oe_n   = oe_n[h];
            ctl.dir    = dir[h];
            ctl.sel_ab = sel_ab[h];
            ctl.sel_ba = sel_ba[h];
        end

        bxc_half #(.WIDTH(HALF_W)) u_half (
            .rst_n (rst_n),
            .clk_ab(ab_clk[h]),
            .clk_ba(ba_clk[h]),
            .ctl   (ctl),
            .a_in  (a_in[h*HALF_W +: HALF_W]),
            .b_in  (b_in[h*HALF_W +: HALF_W]),
            .a_out (a_out[h*HALF_W +: HALF_W]),
            .a_oe  (a_oe[h*HALF_W +: HALF_W]),
            .b_out (b_out[h*HALF_W +: HALF_W]),
            .b_oe  (b_oe[h*HALF_W +: HALF_W])
        );
    end
endmodule

// File: tb/bus_xcvr16_test.sv
module bus_xcvr16_test;
    localparam int HW = 8;
    localparam int NH = 2;
    localparam int W  = HW * NH;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic [NH-1:0] oe_n, dir, ab_clk, ba_clk, sel_ab, sel_ba;
    logic [W-1:0]  a_in, a_out, a_oe, b_in, b_out, b_oe;

    logic [HW-1:0] m_ab [NH];
    logic [HW-1:0] m_ba [NH];

    typedef struct {
        string        req;
        logic [W-1:0] ea;
        logic [W-1:0] eaoe;
        logic [W-1:0] eb;
        logic [W-1:0] eboe;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    bus_xcvr16 uut (
        .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .ab_clk(ab_clk), .ba_clk(ba_clk),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic push_expect(string req);
        exp_t it;
        it.req = req;
        for (int h = 0; h < NH; h++) begin
            logic en;
            en = rst_n && !oe_n[h];
            it.eboe[h*HW +: HW] = {HW{en && dir[h]}};
            it.eaoe[h*HW +: HW] = {HW{en && !dir[h]}};
            it.eb[h*HW +: HW]   = sel_ab[h] ? m_ab[h] : a_in[h*HW +: HW];
            it.ea[h*HW +: HW]   = sel_ba[h] ? m_ba[h] : b_in[h*HW +: HW];
        end
        sbq.push_back(it);
    endtask

    task automatic pulse_ab(int h);
        @(negedge clk);
        ab_clk[h] = 1'b1;
        if (rst_n) m_ab[h] = a_in[h*HW +: HW];
        @(negedge clk);
        ab_clk[h] = 1'b0;
    endtask

    task automatic pulse_ba(int h);
        @(negedge clk);
        ba_clk[h] = 1'b1;
        if (rst_n) m_ba[h] = b_in[h*HW +: HW];
        @(negedge clk);
        ba_clk[h] = 1'b0;
    endtask

    task automatic clear_model();
        for (int h = 0; h < NH; h++) begin
            m_ab[h] = '0;
            m_ba[h] = '0;
        end
    endtask

    always @(posedge clk) begin : monitor
        exp_t it;
        while (sbq.size() > 0) begin
            it = sbq.pop_front();
            checks++;
            if (a_oe !== it.eaoe || b_oe !== it.eboe ||
                (a_out & it.eaoe) !== (it.ea & it.eaoe) ||
                (b_out & it.eboe) !== (it.eb & it.eboe)) begin
                errors++;
                $display("FAIL %s: a_out=%h a_oe=%h b_out=%h b_oe=%h exp a_out=%h a_oe=%h b_out=%h b_oe=%h",
                         it.req, a_out, a_oe, b_out, b_oe, it.ea, it.eaoe, it.eb, it.eboe);
            end
        end
    end

    initial begin
        rst_n = 1'b0; oe_n = '0; dir = '1; ab_clk = '0; ba_clk = '0;
        sel_ab = '0; sel_ba = '0; a_in = 16'hA55A; b_in = 16'h0000;
        clear_model();

        // R8: enables off during reset, capture blocked
        @(negedge clk); push_expect("R8");
        pulse_ab(0); pulse_ab(1);
        @(negedge clk); rst_n = 1'b1; sel_ab = '1; push_expect("R8");

        // R3: live A to B, several patterns
        @(negedge clk); sel_ab = '0; a_in = 16'h0001; push_expect("R3");
        @(negedge clk); a_in = 16'hFF00; push_expect("R3");
        @(negedge clk); a_in = 16'h5AC3; push_expect("R3");

        // R4: live B to A
        @(negedge clk); dir = '0; b_in = 16'h8001; push_expect("R4");
        @(negedge clk); b_in = 16'h00FF; push_expect("R4");
        @(negedge clk); b_in = 16'h3C96; push_expect("R4");

        // R5: isolation, capture still works
        @(negedge clk); oe_n = '1; a_in = 16'h1234; b_in = 16'h5678; push_expect("R5");
        pulse_ab(0); pulse_ab(1); pulse_ba(0); pulse_ba(1);
        @(negedge clk); a_in = 16'hDEAD; b_in = 16'hBEEF; push_expect("R5");

        // R1, R2: reveal stored values
        @(negedge clk); oe_n = '0; dir = '1; sel_ab = '1; push_expect("R1");
        @(negedge clk); dir = '0; sel_ba = '1; push_expect("R2");

        // R6: select flips between stored and live without a clock
        @(negedge clk); sel_ba = '0; push_expect("R6");
        @(negedge clk); dir = '1; sel_ab = '0; push_expect("R6");
        @(negedge clk); sel_ab = 2'b10; push_expect("R6");

        // R9: capture the undriven bus while driving B from A
        @(negedge clk); sel_ab = '0; b_in = 16'hC3E1; push_expect("R9");
        pulse_ba(0); pulse_ba(1); pulse_ab(1);
        @(negedge clk); dir = '0; sel_ba = '1; b_in = 16'h0000; push_expect("R9");
        @(negedge clk); dir = '1; sel_ab = '1; push_expect("R9");

        // R7: halves independent
        @(negedge clk); dir = 2'b01; sel_ab = 2'b01; sel_ba = 2'b00;
        a_in = 16'h7711; b_in = 16'h2299; push_expect("R7");
        pulse_ab(0);
        @(negedge clk); a_in = 16'h0000; dir = '1; sel_ab = '1; push_expect("R7");
        @(negedge clk); oe_n = 2'b10; push_expect("R7");
        @(negedge clk); oe_n = 2'b01; push_expect("R7");

        // R8: asynchronous reset mid-run clears both registers
        @(negedge clk); oe_n = '0; rst_n = 1'b0; clear_model(); push_expect("R8");
        @(negedge clk); rst_n = 1'b1; push_expect("R8");
        @(negedge clk); dir = '0; sel_ba = '1; push_expect("R8");

        @(negedge clk); @(negedge clk);
        wait (sbq.size() == 0);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: run did not end, exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule